// File: doc/BRIEF.md
# Early Tag Access Way-Determination Unit

This block sits beside a set-associative L1 data cache. It resolves, ahead of the cache access itself, which way a memory instruction will touch. It keeps its own mirrored copy of the cache tag arrays and of a small fully associative translation buffer. Each virtual address that enters the load/store queue is looked up against those copies. A full hit yields an exact one-hot way, so the later cache access can power only that way's tag and data arrays. A translation miss or a tag miss is reported as a separate flag, and the access then falls back to probing every way.

The mirrors follow the L1 through update ports that carry the same refill, replacement, invalidate and flush traffic the L1 receives. An update that lands in the same cycle as a lookup is applied first, and the lookup sees the new contents. A single enable pin turns early resolution off. While it is off, each result reports neither a way nor a miss, so every way gets probed.

Lookups enter on a valid/ready stream and leave on a one-deep registered valid/ready stream. `lk_ready` is high whenever the result register is empty or its contents are being taken in the same cycle. A result stays frozen while `res_valid` is high and `res_ready` is low. Update ports are plain strobes that are never back-pressured.

Top module: `eta_way_unit`

## Requirements
- R1: After reset `res_valid` is 0, `lk_ready` is 1, and every mirrored tag and translation entry is invalid, so an enabled lookup reports a translation miss.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high, with `lk_ready = !res_valid || res_ready`. Its result appears with `res_valid` high on the next cycle. While `res_valid` is high and `res_ready` is low, every result output holds.
- R3: When the enabled lookup's page number hits a valid translation entry, and a valid tag in the addressed set equals that entry's physical page number, the result has `res_hit` = 1 and `res_way` with only the bit of the matching way set. If several entries or ways match, the lowest-numbered one wins.
- R4: When no valid translation entry holds the page number, the result has `res_tlb_miss` = 1, `res_hit` = 0 and `res_way` = 0.
- R5: When the translation hits but no valid way in the set holds its physical page number, the result has `res_tag_miss` = 1, `res_hit` = 0 and `res_way` = 0.
- R6: At most one of `res_hit`, `res_tlb_miss` and `res_tag_miss` is high. All three and `res_way` are 0 when `res_valid` is 0. `res_way` is one-hot exactly when `res_hit` is 1.
- R7: A lookup accepted with `eta_enable` = 0 returns `res_hit`, both miss flags and `res_way` all 0, whatever the mirrors hold.
- R8: A tag write or translation write in the same cycle as a lookup is visible to that lookup.
- R9: `tag_inv_en` clears the valid bit of one way in one set, and that takes effect for a lookup in the same cycle. If it targets the same set and way as a concurrent tag write, the entry ends invalid.
- R10: `tlb_flush` invalidates every translation entry in one cycle. A translation write in the same cycle survives the flush.
- R11: A translation write replaces the whole entry at its index, so the old page number stops hitting.
- R12: The address splits as page number = `lk_vaddr[31:12]`, set index = `lk_vaddr[11:6]`, and bits [5:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eta_enable | input | 1 | Early resolution on (1) or bypassed (0), sampled with each lookup |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vaddr | input | 32 | Virtual address of the memory instruction |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_way | output | 4 | One-hot destination way |
| res_hit | output | 1 | Destination way is valid |
| res_tlb_miss | output | 1 | Early translation miss |
| res_tag_miss | output | 1 | Early tag miss |
| tag_wr_en | input | 1 | Tag mirror write strobe |
| tag_wr_set | input | 6 | Set written |
| tag_wr_way | input | 2 | Way written |
| tag_wr_ppn | input | 20 | Physical page number stored as tag |
| tag_inv_en | input | 1 | Tag invalidate strobe |
| tag_inv_set | input | 6 | Set invalidated |
| tag_inv_way | input | 2 | Way invalidated |
| tlb_wr_en | input | 1 | Translation entry write strobe |
| tlb_wr_idx | input | 3 | Translation entry index |
| tlb_wr_vpn | input | 20 | Virtual page number written |
| tlb_wr_ppn | input | 20 | Physical page number written |
| tlb_flush | input | 1 | Invalidate all translation entries |

## Verification
The bench builds the block with its defaults: four ways, 64 sets, eight translation entries and 20-bit page numbers. With these values every way and every translation index can be reached directly. A random phase confines addresses to a few sets and a 16-value pool of page numbers, so duplicate translations, duplicate tags across ways, and updates colliding with lookups or with each other occur often. The lowest-index tie-break and the write-first and invalidate-wins orderings are exercised together with output back-pressure.

// File: rtl/eta_pkg.sv
package eta_pkg;
  typedef enum logic [1:0] {
    ETA_BYPASS   = 2'd0,
    ETA_HIT      = 2'd1,
    ETA_TLB_MISS = 2'd2,
    ETA_TAG_MISS = 2'd3
  } eta_kind_e;
endpackage

// File: rtl/eta_tlb.sv
// Mirrored fully associative translation buffer with write-first lookup.
module eta_tlb #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PPN_W-1:0]           wr_ppn,
  input  logic [VPN_W-1:0]           lk_vpn,
  output logic                       lk_hit,
  output logic [PPN_W-1:0]           lk_ppn
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [VPN_W-1:0]   vpn_n [ENTRIES];
  logic [PPN_W-1:0]   ppn_n [ENTRIES];
  logic [ENTRIES-1:0] valid_n;
  logic [ENTRIES-1:0] match;

  // next state: flush first, then the write lands on top of it
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_en && (wr_idx == IDX_W'(e))) begin
        valid_n[e] = 1'b1;
        vpn_n[e]   = wr_vpn;
        ppn_n[e]   = wr_ppn;
      end else begin
        valid_n[e] = valid_q[e] & ~flush;
        vpn_n[e]   = vpn_q[e];
        ppn_n[e]   = ppn_q[e];
      end
      match[e] = valid_n[e] && (vpn_n[e] == lk_vpn);
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        lk_hit = 1'b1;
        lk_ppn = ppn_n[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end
endmodule

// File: rtl/eta_tag_way.sv
// One way of the mirrored tag array; read port forwards same-cycle updates.
module eta_tag_way #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic                    inv_en,
  input  logic [$clog2(SETS)-1:0] inv_set,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic                    rd_valid,
  output logic [TAG_W-1:0]        rd_tag
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  vld_q;

  logic wr_hit, inv_hit;
  assign wr_hit  = wr_en  && (wr_set  == rd_set);
  assign inv_hit = inv_en && (inv_set == rd_set);

  // invalidate outranks a write to the same entry
  always_comb begin
    if (inv_hit)     rd_valid = 1'b0;
    else if (wr_hit) rd_valid = 1'b1;
    else             rd_valid = vld_q[rd_set];
    rd_tag = wr_hit ? wr_tag : tag_q[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_set]  <= 1'b1;
      if (inv_en) vld_q[inv_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set] <= wr_tag;
  end
endmodule

// File: rtl/eta_way_pick.sv
// Reduces a way-match vector to a one-hot choice, lowest index first.
module eta_way_pick #(
  parameter int unsigned WAYS = 4
) (
  input  logic [WAYS-1:0] match,
  output logic [WAYS-1:0] onehot,
  output logic            any
);
  always_comb begin
    onehot = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) onehot = WAYS'(1) << w;
    end
    any = |match;
  end
endmodule

// File: rtl/eta_way_unit.sv
module eta_way_unit
  import eta_pkg::*;
#(
  parameter int unsigned WAYS        = 4,
  parameter int unsigned SETS        = 64,
  parameter int unsigned TLB_ENTRIES = 8,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 20,
  parameter int unsigned LINE_OFF_W  = 6,
  parameter int unsigned PAGE_OFF_W  = 12,
  localparam int unsigned VA_W       = VPN_W + PAGE_OFF_W,
  localparam int unsigned SET_W      = $clog2(SETS),
  localparam int unsigned WAY_W      = $clog2(WAYS),
  localparam int unsigned TIDX_W     = $clog2(TLB_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eta_enable,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WAYS-1:0]   res_way,
  output logic              res_hit,
  output logic              res_tlb_miss,
  output logic              res_tag_miss,
  input  logic              tag_wr_en,
  input  logic [SET_W-1:0]  tag_wr_set,
  input  logic [WAY_W-1:0]  tag_wr_way,
  input  logic [PPN_W-1:0]  tag_wr_ppn,
  input  logic              tag_inv_en,
  input  logic [SET_W-1:0]  tag_inv_set,
  input  logic [WAY_W-1:0]  tag_inv_way,
  input  logic              tlb_wr_en,
  input  logic [TIDX_W-1:0] tlb_wr_idx,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PPN_W-1:0]  tlb_wr_ppn,
  input  logic              tlb_flush
);
  // address split (R12)
  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set;
  logic             unused_va;
  assign lk_vpn    = lk_vaddr[VA_W-1:PAGE_OFF_W];
  assign lk_set    = lk_vaddr[LINE_OFF_W+SET_W-1:LINE_OFF_W];
  assign unused_va = ^lk_vaddr;

  // translation mirror
  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;

  eta_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_tlb (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (tlb_flush),
    .wr_en  (tlb_wr_en),
    .wr_idx (tlb_wr_idx),
    .wr_vpn (tlb_wr_vpn),
    .wr_ppn (tlb_wr_ppn),
    .lk_vpn (lk_vpn),
    .lk_hit (tlb_hit),
    .lk_ppn (tlb_ppn)
  );

  // tag mirror, one store per way
  logic [WAYS-1:0] way_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             rd_valid;
    logic [PPN_W-1:0] rd_tag;
    logic             wr_sel, inv_sel;

    assign wr_sel  = tag_wr_en  && (tag_wr_way  == WAY_W'(w));
    assign inv_sel = tag_inv_en && (tag_inv_way == WAY_W'(w));

    eta_tag_way #(
      .SETS  (SETS),
      .TAG_W (PPN_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sel),
      .wr_set   (tag_wr_set),
      .wr_tag   (tag_wr_ppn),
      .inv_en   (inv_sel),
      .inv_set  (tag_inv_set),
      .rd_set   (lk_set),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag)
    );

    assign way_match[w] = rd_valid && (rd_tag == tlb_ppn);
  end

  logic [WAYS-1:0] pick_way;
  logic            pick_any;

  eta_way_pick #(.WAYS(WAYS)) u_pick (
    .match  (way_match),
    .onehot (pick_way),
    .any    (pick_any)
  );

  // classify the lookup
  eta_kind_e       kind_d;
  logic [WAYS-1:0] way_d;

  always_comb begin
    way_d = '0;
    if (!eta_enable)    kind_d = ETA_BYPASS;
    else if (!tlb_hit)  kind_d = ETA_TLB_MISS;
    else if (!pick_any) kind_d = ETA_TAG_MISS;
    else begin
      kind_d = ETA_HIT;
      way_d  = pick_way;
    end
  end

  // one-deep result stage with back-pressure
  logic            vld_q;
  eta_kind_e       kind_q;
  logic [WAYS-1:0] way_q;
  logic            accept;

  assign lk_ready = !vld_q || res_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= ETA_BYPASS;
      way_q  <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      kind_q <= kind_d;
      way_q  <= way_d;
    end else if (res_ready) begin
      vld_q  <= 1'b0;
      kind_q <= ETA_BYPASS;
      way_q  <= '0;
    end
  end

  assign res_valid    = vld_q;
  assign res_way      = way_q;
  assign res_hit      = (kind_q == ETA_HIT);
  assign res_tlb_miss = (kind_q == ETA_TLB_MISS);
  assign res_tag_miss = (kind_q == ETA_TAG_MISS);
endmodule

// File: rtl/eta_way_unit_chk.sv
module eta_way_unit_chk #(
  parameter int unsigned WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eta_enable,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [WAYS-1:0] res_way,
  input logic            res_hit,
  input logic            res_tlb_miss,
  input logic            res_tag_miss,
  input logic            tlb_flush,
  input logic            tlb_wr_en
);
  assert_accept_gives_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_way, res_hit, res_tlb_miss, res_tag_miss}));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_hit, res_tlb_miss, res_tag_miss}) <= 1);

  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_hit || res_tlb_miss || res_tag_miss) && (res_way == '0));

  assert_way_onehot_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> $countones(res_way) == 1);

  assert_no_way_without_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_way == '0);

  assert_bypass_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !eta_enable |=> !res_hit && !res_tlb_miss && !res_tag_miss);

  assert_flush_forces_tlb_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && eta_enable && tlb_flush && !tlb_wr_en |=> res_tlb_miss);
endmodule

bind eta_way_unit eta_way_unit_chk #(.WAYS(WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eta_enable   (eta_enable),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_way      (res_way),
  .res_hit      (res_hit),
  .res_tlb_miss (res_tlb_miss),
  .res_tag_miss (res_tag_miss),
  .tlb_flush    (tlb_flush),
  .tlb_wr_en    (tlb_wr_en)
);

// File: tb/eta_way_unit_tb.sv
`timescale 1ns/1ps
module eta_way_unit_tb;
  localparam int NW = 4, NS = 64, NT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        eta_enable = 0, lk_valid = 0, res_ready = 1;
  logic [31:0] lk_vaddr = '0;
  logic        lk_ready, res_valid, res_hit, res_tlb_miss, res_tag_miss;
  logic [3:0]  res_way;
  logic        tag_wr_en = 0, tag_inv_en = 0, tlb_wr_en = 0, tlb_flush = 0;
  logic [5:0]  tag_wr_set = '0, tag_inv_set = '0;
  logic [1:0]  tag_wr_way = '0, tag_inv_way = '0;
  logic [19:0] tag_wr_ppn = '0, tlb_wr_vpn = '0, tlb_wr_ppn = '0;
  logic [2:0]  tlb_wr_idx = '0;

  eta_way_unit u_dut (.*);

  // behavioural reference state
  logic [19:0] m_tag [NW][NS];
  bit          m_tv  [NW][NS];
  logic [19:0] m_vpn [NT];
  logic [19:0] m_ppn [NT];
  bit          m_lv  [NT];
  bit          e_valid, e_hit, e_tm, e_gm;
  logic [3:0]  e_way;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) m_tv[w][s] = 0;
    for (int i = 0; i < NT; i++) m_lv[i] = 0;
    e_valid = 0; e_hit = 0; e_tm = 0; e_gm = 0; e_way = '0;
  endtask

  // one clock: model applies updates, looks up, compares after the edge
  task automatic step();
    bit rdy, acc, n_hit, n_tm, n_gm, found;
    logic [3:0]  n_way;
    logic [19:0] vpn, ppn;
    int set;
    #1;
    rdy = !e_valid || res_ready;
    check(lk_ready === rdy, cur_req, "lk_ready", lk_ready, rdy);
    acc = lk_valid && rdy;
    if (tag_wr_en) begin
      m_tag[tag_wr_way][tag_wr_set] = tag_wr_ppn;
      m_tv[tag_wr_way][tag_wr_set]  = 1;
    end
    if (tag_inv_en) m_tv[tag_inv_way][tag_inv_set] = 0;
    if (tlb_flush) for (int i = 0; i < NT; i++) m_lv[i] = 0;
    if (tlb_wr_en) begin
      m_vpn[tlb_wr_idx] = tlb_wr_vpn;
      m_ppn[tlb_wr_idx] = tlb_wr_ppn;
      m_lv[tlb_wr_idx]  = 1;
    end
    n_hit = 0; n_tm = 0; n_gm = 0; n_way = '0;
    if (acc && eta_enable) begin
      vpn = lk_vaddr[31:12];
      set = int'(lk_vaddr[11:6]);
      found = 0; ppn = '0;
      for (int i = 0; i < NT; i++)
        if (!found && m_lv[i] && m_vpn[i] == vpn) begin found = 1; ppn = m_ppn[i]; end
      if (!found) n_tm = 1;
      else begin
        for (int w = 0; w < NW; w++)
          if (!n_hit && m_tv[w][set] && m_tag[w][set] == ppn) begin n_hit = 1; n_way[w] = 1'b1; end
        if (!n_hit) n_gm = 1;
      end
    end
    @(posedge clk);
    #1;
    if (acc) begin
      e_valid = 1; e_hit = n_hit; e_tm = n_tm; e_gm = n_gm; e_way = n_way;
    end else if (res_ready) begin
      e_valid = 0; e_hit = 0; e_tm = 0; e_gm = 0; e_way = '0;
    end
    check(res_valid === e_valid,   cur_req, "res_valid",    res_valid,    e_valid);
    check(res_hit === e_hit,       cur_req, "res_hit",      res_hit,      e_hit);
    check(res_tlb_miss === e_tm,   cur_req, "res_tlb_miss", res_tlb_miss, e_tm);
    check(res_tag_miss === e_gm,   cur_req, "res_tag_miss", res_tag_miss, e_gm);
    check(res_way === e_way,       cur_req, "res_way",      res_way,      e_way);
  endtask

  task automatic idle();
    lk_valid = 0; tag_wr_en = 0; tag_inv_en = 0; tlb_wr_en = 0; tlb_flush = 0;
    res_ready = 1; eta_enable = 1;
  endtask

  function automatic logic [31:0] va(logic [19:0] vpn, int set, logic [5:0] off);
    return {vpn, 6'(set), off};
  endfunction

  task automatic look(logic [31:0] a);
    lk_valid = 1; lk_vaddr = a; step(); idle();
  endtask

  task automatic twr(int set, int way, logic [19:0] ppn);
    tag_wr_en = 1; tag_wr_set = 6'(set); tag_wr_way = 2'(way); tag_wr_ppn = ppn;
  endtask

  task automatic tinv(int set, int way);
    tag_inv_en = 1; tag_inv_set = 6'(set); tag_inv_way = 2'(way);
  endtask

  task automatic lwr(int idx, logic [19:0] vpn, logic [19:0] ppn);
    tlb_wr_en = 1; tlb_wr_idx = 3'(idx); tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    #1;
    // R1: reset state at the ports
    check(res_valid === 1'b0, "R1", "res_valid after reset", res_valid, 0);
    check(lk_ready === 1'b1,  "R1", "lk_ready after reset",  lk_ready, 1);
    cur_req = "R1";
    look(va(20'h12345, 3, 6'h0));

    // fill the mirrors: entry i maps 0x100+i -> 0xA0000+i
    cur_req = "R11";
    for (int i = 0; i < NT; i++) begin lwr(i, 20'h100 + 20'(i), 20'hA0000 + 20'(i)); step(); idle(); end
    foreach (m_vpn[i]) ;
    for (int k = 0; k < 3; k++) begin
      int s;
      s = (k == 0) ? 0 : (k == 1) ? 5 : 63;
      for (int w = 0; w < NW; w++) begin twr(s, w, 20'hA0000 + 20'((w + s) % 8)); step(); idle(); end
    end

    // R3: each way hits in each filled set
    cur_req = "R3";
    for (int k = 0; k < 3; k++) begin
      int s;
      s = (k == 0) ? 0 : (k == 1) ? 5 : 63;
      for (int w = 0; w < NW; w++) look(va(20'h100 + 20'((w + s) % 8), s, 6'h15));
    end
    // R12: offset bits ignored, set field selects the set
    cur_req = "R12";
    look(va(20'h101, 0, 6'h3F));
    look(va(20'h101, 63, 6'h00));
    look(va(20'h106, 5, 6'h2A));
    // R4 and R5
    cur_req = "R4";
    look(va(20'h999, 0, 6'h0));
    cur_req = "R5";
    look(va(20'h107, 0, 6'h0));
    // R7: disabled lookups on a hitting and a missing address
    cur_req = "R7";
    eta_enable = 0; lk_valid = 1; lk_vaddr = va(20'h100, 0, 6'h0); step(); idle();
    eta_enable = 0; lk_valid = 1; lk_vaddr = va(20'h999, 0, 6'h0); step(); idle();
    // R2: back-pressure with a stream of lookups
    cur_req = "R2";
    for (int c = 0; c < 6; c++) begin
      lk_valid = 1; lk_vaddr = va(20'h100 + 20'(c % 4), 0, 6'h0);
      res_ready = (c >= 3); eta_enable = 1; step();
    end
    idle(); step();
    // R8: same-cycle tag write and translation write are seen
    cur_req = "R8";
    twr(10, 2, 20'hA0005); lk_valid = 1; lk_vaddr = va(20'h105, 10, 6'h0); step(); idle();
    lwr(6, 20'h321, 20'hA0005); lk_valid = 1; lk_vaddr = va(20'h321, 10, 6'h0); step(); idle();
    // R9: invalidate, and invalidate beating a concurrent write
    cur_req = "R9";
    tinv(10, 2); lk_valid = 1; lk_vaddr = va(20'h105, 10, 6'h0); step(); idle();
    twr(10, 1, 20'hA0005); tinv(10, 1); lk_valid = 1; lk_vaddr = va(20'h105, 10, 6'h0); step(); idle();
    look(va(20'h105, 10, 6'h0));
    // R11: rewriting an entry drops the old page number
    cur_req = "R11";
    lwr(3, 20'h777, 20'hA0003); step(); idle();
    look(va(20'h103, 0, 6'h0));
    look(va(20'h777, 0, 6'h0));
    // R10: flush with a surviving concurrent write
    cur_req = "R10";
    tlb_flush = 1; lwr(1, 20'h101, 20'hA0001); lk_valid = 1; lk_vaddr = va(20'h100, 0, 6'h0); step(); idle();
    look(va(20'h101, 0, 6'h0));
    look(va(20'h102, 0, 6'h0));
    tlb_flush = 1; lk_valid = 1; lk_vaddr = va(20'h101, 0, 6'h0); step(); idle();

    // R6 and everything else under a random mix with collisions
    cur_req = "R6";
    for (int c = 0; c < 3000; c++) begin
      tag_wr_en  = ($urandom % 4) == 0;
      tag_wr_set = 6'($urandom % 4); tag_wr_way = 2'($urandom); tag_wr_ppn = 20'hA0000 + 20'($urandom % 16);
      tag_inv_en = ($urandom % 8) == 0;
      tag_inv_set = 6'($urandom % 4); tag_inv_way = 2'($urandom);
      tlb_wr_en  = ($urandom % 6) == 0;
      tlb_wr_idx = 3'($urandom); tlb_wr_vpn = 20'h100 + 20'($urandom % 16); tlb_wr_ppn = 20'hA0000 + 20'($urandom % 16);
      tlb_flush  = ($urandom % 64) == 0;
      lk_valid   = ($urandom % 4) != 0;
      lk_vaddr   = va(20'h100 + 20'($urandom % 16), int'($urandom % 4), 6'($urandom));
      eta_enable = ($urandom % 8) != 0;
      res_ready  = ($urandom % 4) != 0;
      step();
    end
    idle(); step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule